// File: doc/BRIEF.md
# Buffered Synchronous Serial Master

This block is a serial master that sends one buffered word at a time. Software pushes words into a small first-in first-out transmit store through a write port. The engine takes the oldest stored word, shifts it out on a serial clock and data-out line, and at the same time collects a word from the data-in line. Two enables select the direction: transmit only, receive only, or both at once. In receive-only mode the words written into the store act as dummy data that start each transfer.

A transfer does not retire until the last received word has been taken. When a shift finishes while the receive holding register still holds an unread word, the engine stalls. The holding-register load, the completion pulse and the retirement of the store entry all wait until the host strobes the read. In transmit-only mode the holding register counts as already read, so a word retires as soon as it has been shifted.

Software sees a busy flag, the number of words still in the store and a full flag. It also gets a one-cycle completion pulse and a one-cycle overflow pulse. Clearing both enables abandons all work in progress.

Top module: `bufd_serial_master`

## Requirements
- R1: After reset the outputs are `busy`=0, `level`=0, `full`=0, `sck`=1, `irq_done`=0, `irq_ovf`=0, `rx_avail`=0 and `rx_data`=0.
- R2: A write (`wr_valid` high while `tx_en` or `rx_en` is high and `full` is low) stores `wr_data` at the tail of the store. One cycle later `level` has risen by one and `busy` is 1.
- R3: A write while both `tx_en` and `rx_en` are low is discarded. `level` stays unchanged and `irq_overflow` does not pulse.
- R4: When an enable is set, the engine is idle and `level` is not 0, the engine loads the oldest word at a clock edge. Over the next 2·DATA_W·HALF_PERIOD cycles it drives the word MSB first. `sck` idles high and each half period lasts HALF_PERIOD cycles. `sdo` changes on the falling edges of `sck`, and `sdi` is sampled on the rising edges.
- R5: When `rx_en` is 1 and `rx_avail` is 0 at the end of a word, the received word is written to `rx_data` and `rx_avail` is set. On the following edge `irq_done` pulses for one cycle and `level` drops by one.
- R6: When `rx_en` is 1 and `rx_avail` is 1 at the end of a word, the engine holds. The `rx_data` load, the `irq_done` pulse and the `level` decrement all wait. The held word completes on the edge after the one at which `rx_read` clears `rx_avail`.
- R7: With `rx_en` at 0, a finished word completes on the next edge regardless of `rx_avail`, and `rx_data` and `rx_avail` are left untouched.
- R8: `busy` returns to 0 on the completion that leaves the store empty, unless a write is accepted on the same edge.
- R9: `level` is the write pointer minus the read pointer, on $clog2(DEPTH)+1 bits. `full` is 1 exactly when `level` equals DEPTH, and `level` is nonzero only while `busy` is 1.
- R10: A write while `full` is 1 is dropped and `irq_ovf` is 1 for exactly the next cycle.
- R11: Clearing both enables abandons any word in progress. On the next cycle `level`=0, `busy`=0 and `sck`=1, and the abandoned word raises no `irq_done`.
- R12: `rx_read` clears `rx_avail`, except on an edge where a new word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| wr_valid | input | 1 | Write strobe into the transmit store |
| wr_data | input | DATA_W | Word to store |
| rx_read | input | 1 | Host has read the receive holding register |
| rx_data | output | DATA_W | Receive holding register |
| rx_avail | output | 1 | Holding register contains an unread word |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer status flag |
| level | output | $clog2(DEPTH)+1 | Words left in the store |
| full | output | 1 | Store is full |
| irq_done | output | 1 | One-cycle transfer completion pulse |
| irq_ovf | output | 1 | One-cycle overflow pulse |

## Verification
The bench builds the block with DATA_W=8, DEPTH=8 and HALF_PERIOD=2, so one word takes 32 cycles of shifting. Ten writes issued back to back therefore fill the store before the first word retires, which brings the full flag and the overflow pulse within reach. The short word also lets an abort be placed in mid-shift, and lets a read-pending stall be held across several word times. A behavioural slave on the serial lines checks every shifted-out word and returns known patterns, so received data and the stall are checked against independently computed values.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RX     = 2'b01,
    MODE_TX     = 2'b10,
    MODE_DUPLEX = 2'b11
  } sio_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_SHIFT = 2'b01,
    PH_WAIT  = 2'b10
  } sio_phase_e;

  function automatic sio_mode_e mode_of(input logic tx, input logic rx);
    return sio_mode_e'({tx, rx});
  endfunction

  function automatic logic mode_runs(input sio_mode_e m);
    return m != MODE_OFF;
  endfunction

  function automatic logic mode_captures(input sio_mode_e m);
    return (m == MODE_RX) || (m == MODE_DUPLEX);
  endfunction

endpackage

// File: rtl/sio_txbuf.sv
module sio_txbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      push,
  input  logic [DATA_W-1:0]         push_data,
  input  logic                      pop,
  output logic [DATA_W-1:0]         head_data,
  output logic [$clog2(DEPTH):0]    level,
  output logic                      full,
  output logic                      empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;

  // Extra pointer bit tells a full store from an empty one.
  function automatic logic [PW-1:0] fill_of(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  assign level     = fill_of(wp_q, rp_q);
  assign full      = (level == PW'(DEPTH));
  assign empty     = (level == '0);
  assign head_data = slot_q[rp_q[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (clear) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wp_q[AW-1:0] == AW'(g))) slot_q[g] <= push_data;
    end
  end

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W      = 8,
  parameter int HALF_PERIOD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic [DATA_W-1:0] word,
  output logic              word_end
);
  localparam int TW   = $clog2(2 * DATA_W);
  localparam int DIVW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam int LAST = 2 * DATA_W - 1;

  logic              active_q;
  logic [DIVW-1:0]   div_q;
  logic [TW-1:0]     edge_q;
  logic [DATA_W-1:0] sh_q;
  logic              sck_q, sdo_q;
  logic              tick;

  assign tick     = active_q && (div_q == DIVW'(HALF_PERIOD - 1));
  assign word_end = tick && (edge_q == TW'(LAST));
  assign sck      = sck_q;
  assign sdo      = sdo_q;
  assign word     = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      sh_q     <= '0;
      sck_q    <= 1'b1;
      sdo_q    <= 1'b1;
    end else if (abort) begin
      active_q <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      sck_q    <= 1'b1;
    end else if (start) begin
      active_q <= 1'b1;
      div_q    <= '0;
      edge_q   <= '0;
      sh_q     <= load_data;
    end else if (active_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        edge_q <= edge_q + 1'b1;
        if (!edge_q[0]) begin
          sck_q <= 1'b0;
          sdo_q <= sh_q[DATA_W-1];
        end else begin
          sck_q <= 1'b1;
          sh_q  <= {sh_q[DATA_W-2:0], sdi};
        end
        if (word_end) active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bufd_serial_master.sv
module bufd_serial_master
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int HALF_PERIOD = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_en,
  input  logic                   rx_en,
  input  logic                   wr_valid,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rx_read,
  output logic [DATA_W-1:0]      rx_data,
  output logic                   rx_avail,
  output logic                   sck,
  output logic                   sdo,
  input  logic                   sdi,
  output logic                   busy,
  output logic [$clog2(DEPTH):0] level,
  output logic                   full,
  output logic                   irq_done,
  output logic                   irq_ovf
);
  localparam int LW = $clog2(DEPTH) + 1;

  sio_mode_e         mode;
  sio_phase_e        phase_q;
  logic              enabled, capture;
  logic              push, ovf_hit, start, word_end, done_evt, pend, last_word, empty;
  logic [DATA_W-1:0] head_data, shift_word, rx_q;
  logic              avail_q, busy_q, irq_done_q, irq_ovf_q;

  assign mode      = mode_of(tx_en, rx_en);
  assign enabled   = mode_runs(mode);
  assign capture   = mode_captures(mode);

  // Named events for the checker.
  assign push      = wr_valid && enabled && !full;
  assign ovf_hit   = wr_valid && enabled && full;
  assign start     = enabled && (phase_q == PH_IDLE) && !empty;
  assign pend      = (phase_q == PH_WAIT);
  assign done_evt  = enabled && pend && (!capture || !avail_q);
  assign last_word = (level == LW'(1));

  sio_txbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!enabled),
    .push      (push),
    .push_data (wr_data),
    .pop       (done_evt),
    .head_data (head_data),
    .level     (level),
    .full      (full),
    .empty     (empty)
  );

  sio_shifter #(.DATA_W(DATA_W), .HALF_PERIOD(HALF_PERIOD)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (!enabled),
    .start     (start),
    .load_data (head_data),
    .sdi       (sdi),
    .sck       (sck),
    .sdo       (sdo),
    .word      (shift_word),
    .word_end  (word_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else if (!enabled) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (start)    phase_q <= PH_SHIFT;
        PH_SHIFT: if (word_end) phase_q <= PH_WAIT;
        PH_WAIT:  if (done_evt) phase_q <= PH_IDLE;
        default:                phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (!enabled) begin
      busy_q <= 1'b0;
    end else if (push) begin
      busy_q <= 1'b1;
    end else if (done_evt && last_word) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      avail_q <= 1'b0;
    end else if (done_evt && capture) begin
      rx_q    <= shift_word;
      avail_q <= 1'b1;
    end else if (rx_read) begin
      avail_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_done_q <= 1'b0;
      irq_ovf_q  <= 1'b0;
    end else begin
      irq_done_q <= done_evt;
      irq_ovf_q  <= ovf_hit;
    end
  end

  assign busy     = busy_q;
  assign rx_data  = rx_q;
  assign rx_avail = avail_q;
  assign irq_done = irq_done_q;
  assign irq_ovf  = irq_ovf_q;

endmodule

// File: rtl/sio_master_chk.sv
module sio_master_chk #(
  parameter int LW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          rx_en,
  input logic          wr_valid,
  input logic          full,
  input logic [LW-1:0] level,
  input logic          busy,
  input logic          sck,
  input logic          irq_done,
  input logic          irq_ovf,
  input logic          rx_avail,
  input logic          pend,
  input logic          done_evt
);
  logic en;
  assign en = tx_en || rx_en;

  a_r2_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && en && !full) |=> busy);

  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r9_level_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> busy);

  a_r10_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && en && full) |=> irq_ovf);

  a_r6_hold_while_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && rx_en && rx_avail) |=> !irq_done);

  a_r5_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !(wr_valid && !full)) |=> (level == $past(level) - 1'b1));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  a_r8_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && (level == LW'(1)) && !wr_valid) |=> !busy);

  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (level == '0 && !busy && sck));

  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

endmodule

bind bufd_serial_master sio_master_chk #(.LW($clog2(DEPTH) + 1), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .wr_valid (wr_valid),
  .full     (full),
  .level    (level),
  .busy     (busy),
  .sck      (sck),
  .irq_done (irq_done),
  .irq_ovf  (irq_ovf),
  .rx_avail (rx_avail),
  .pend     (pend),
  .done_evt (done_evt)
);

// File: tb/test_bufd_serial_master.sv
module test_bufd_serial_master;
  localparam int DW   = 8;
  localparam int DEP  = 8;
  localparam int HALF = 2;
  localparam int WORD_CYC = 2 * DW * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, wr_valid = 1'b0, rx_read = 1'b0, sdi = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rx_data;
  logic rx_avail, sck, sdo, busy, full, irq_done, irq_ovf;
  logic [3:0] level;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  bufd_serial_master #(.DATA_W(DW), .DEPTH(DEP), .HALF_PERIOD(HALF)) i_bufd_serial_master (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .rx_read(rx_read),
    .rx_data(rx_data), .rx_avail(rx_avail), .sck(sck), .sdo(sdo), .sdi(sdi),
    .busy(busy), .level(level), .full(full), .irq_done(irq_done), .irq_ovf(irq_ovf)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'h3C ^ 8'(i * 29);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mq[$];
  logic [7:0] tx_log[$];
  int   m_phase = 0, m_cnt = 0, m_xidx = 0;
  bit   m_busy = 0, m_done = 0, m_ovf = 0, m_avail = 0;
  logic [7:0] m_rx = '0, m_cur_rx = '0;

  always @(posedge clk) begin : model
    int  osz;
    bit  comp, en;
    if (!rst_n) begin
      mq.delete(); tx_log.delete();
      m_phase = 0; m_busy = 0; m_done = 0; m_ovf = 0; m_avail = 0; m_rx = '0; m_xidx = 0;
    end else begin
      en = tx_en || rx_en;
      osz = mq.size();
      comp = en && (m_phase == 2) && (!rx_en || !m_avail);
      m_done = comp;
      m_ovf = en && wr_valid && (osz == DEP);
      if (!en) begin
        mq.delete(); tx_log.delete();
        m_phase = 0; m_busy = 0; m_xidx = 0;
        if (rx_read) m_avail = 0;
      end else begin
        if (m_phase == 0 && osz > 0) begin
          m_phase = 1; m_cnt = WORD_CYC;
          tx_log.push_back(mq[0]);
          m_cur_rx = pat(m_xidx); m_xidx++;
        end else if (m_phase == 1) begin
          m_cnt--;
          if (m_cnt == 0) m_phase = 2;
        end else if (comp) begin
          m_phase = 0;
        end
        if (comp && rx_en) begin m_rx = m_cur_rx; m_avail = 1; end
        else if (rx_read) m_avail = 0;
        if (comp) void'(mq.pop_front());
        if (wr_valid && osz < DEP) begin mq.push_back(wr_data); m_busy = 1; end
        else if (comp && osz == 1) m_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 busy", busy, m_busy);
      chk("R9 level", level, mq.size());
      chk("R9 full", full, (mq.size() == DEP));
      chk("R5 irq_done", irq_done, m_done);
      chk("R10 irq_ovf", irq_ovf, m_ovf);
      chk("R5 rx_data", rx_data, m_rx);
      chk("R12 rx_avail", rx_avail, m_avail);
    end
  end

  // ---------------- behavioural serial slave ----------------
  bit prev_sck = 1;
  int s_fall = 0, s_rise = 0, s_idx = 0;
  logic [7:0] s_word = '0;
  int ovf_seen = 0, done_seen = 0;

  always @(negedge clk) begin
    if (irq_ovf) ovf_seen++;
    if (irq_done) done_seen++;
    if (!rst_n || !(tx_en || rx_en)) begin
      s_fall = 0; s_rise = 0; s_idx = 0; prev_sck = sck;
    end else begin
      if (prev_sck && !sck) begin
        sdi = pat(s_idx)[7 - s_fall];
        s_fall++;
      end
      if (!prev_sck && sck) begin
        s_word = {s_word[6:0], sdo};
        s_rise++;
        if (s_rise == DW) begin
          if (tx_log.size() > 0) chk("R4 sdo word MSB first", s_word, tx_log.pop_front());
          else chk("R4 unexpected word", 1, 0);
          s_idx++; s_rise = 0; s_fall = 0;
        end
      end
      prev_sck = sck;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    cyc(3);
    chk("R1 busy", busy, 0);  chk("R1 level", level, 0); chk("R1 sck", sck, 1);
    chk("R1 irqs", {irq_done, irq_ovf}, 0); chk("R1 rx", {rx_avail, rx_data}, 0);
    chk("R1 full", full, 0);
    rst_n = 1'b1;
    cyc(2);

    // R3: writes with both enables low
    base = ovf_seen;
    wr(8'h11); wr(8'h22);
    cyc(2);
    chk("R3 level after disabled writes", level, 0);
    chk("R3 no overflow", ovf_seen - base, 0);

    // R2, R5, R6, R12: full duplex with a held read
    tx_en = 1'b1; rx_en = 1'b1;
    wr(8'hA1);
    chk("R2 level after write", level, 1);
    chk("R2 busy after write", busy, 1);
    wr(8'hB2); wr(8'hC3);
    cyc(110);
    chk("R6 held level", level, 2);
    chk("R5 first rx word", rx_data, pat(0));
    chk("R6 avail while held", rx_avail, 1);
    rd();
    chk("R12 read clears avail", rx_avail, 0);
    cyc(1);
    chk("R6 released level", level, 1);
    chk("R6 released rx word", rx_data, pat(1));
    cyc(40);
    rd();
    cyc(3);
    chk("R8 idle after drain", busy, 0);
    chk("R5 last rx word", rx_data, pat(2));

    // R7: transmit only, holding register left unread
    rx_en = 1'b0;
    wr(8'h5A); wr(8'h96);
    cyc(90);
    chk("R7 tx-only drained", level, 0);
    chk("R7 rx untouched", {rx_avail, rx_data}, {1'b1, pat(2)});

    // R10: back-to-back writes overflow the store
    base = ovf_seen;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wr_valid = 1'b1; wr_data = 8'(8'h40 + i);
    end
    @(negedge clk); wr_valid = 1'b0;
    chk("R10 store full", full, 1);
    chk("R9 level at full", level, DEP);
    cyc(2);
    chk("R10 overflow pulses", ovf_seen - base, 2);
    cyc(8 * (WORD_CYC + 2) + 10);
    chk("R8 busy clear after burst", busy, 0);

    // R11: abort mid-shift
    wr(8'hE7); wr(8'h18);
    cyc(12);
    base = done_seen;
    @(negedge clk); tx_en = 1'b0;
    cyc(1);
    chk("R11 level", level, 0); chk("R11 busy", busy, 0); chk("R11 sck", sck, 1);
    cyc(50);
    chk("R11 no completion", done_seen - base, 0);

    // R4 and R5: receive only with a dummy word
    rx_en = 1'b1;
    rd();
    wr(8'hFF);
    cyc(WORD_CYC + 6);
    chk("R5 rx-only word", rx_data, pat(0));
    chk("R5 rx-only avail", rx_avail, 1);
    chk("R8 rx-only idle", busy, 0);
    rd();
    cyc(3);
    finish_run();
  end

endmodule